// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This block performs decimal arithmetic on one byte that holds two packed BCD digits. It can add, subtract or negate, and it uses an incoming extend bit as the carry or borrow from a less significant byte. This lets software or a sequencer chain several invocations to process decimal numbers of any length, starting at the least significant byte. A single nibble-correcting datapath serves all three operations. Addition and subtraction use two operands. Negation subtracts the destination from zero.

A one-cycle `start` pulse captures the operands, the operation code and the incoming X and Z flags. One clock later the unit presents the registered result byte and the new flags, and raises `valid` for that one cycle. The outputs keep their values until the next start. The control is a two-state machine. `ST_IDLE` waits for a start and moves to `ST_PRESENT` when `start` is high (transition LAUNCH). `ST_PRESENT` drives `valid`. From there, another start keeps the machine in `ST_PRESENT` (transition CHAIN), and no start returns it to `ST_IDLE` (transition SETTLE).

Zero reporting is cumulative across a chain. A non-zero byte clears Z. A zero byte passes the incoming Z through unchanged. A chain that enters with Z set therefore ends with Z set only if every byte was zero.

Top module: `bcd_byte_alu`

## Requirements
- R1: Each nibble holds one decimal digit coded 0000 to 1001, and bits 7:4 hold the tens digit. `op` selects the operation: 2'b00 adds, 2'b01 subtracts, 2'b10 negates, and 2'b11 behaves exactly like 2'b00.
- R2: Add produces (dst + src + x_in) mod 100 in BCD. x_out and c_out are both 1 exactly when the decimal sum exceeds 99.
- R3: Subtract produces (dst - src - x_in) mod 100 in BCD. x_out and c_out are both 1 exactly when the decimal difference is negative.
- R4: Negate produces (0 - dst - x_in) mod 100. With x_in=0 this is the ten's complement (45 gives 55), and with x_in=1 it is the nine's complement (45 gives 54). The src input is ignored.
- R5: Negate sets x_out and c_out when dst or x_in is non-zero. It clears both, and returns 00, when dst is 00 and x_in is 0.
- R6: z_out is 0 when the captured result is non-zero. Otherwise z_out equals the captured z_in.
- R7: `valid` is high in the cycle after each cycle in which `start` is high, and low in every other cycle.
- R8: In the cycle after a cycle with `start` low, result, x_out, c_out, z_out and n_out are unchanged.
- R9: While reset is asserted and after it is released, valid, result and all flags are 0 until the first start.
- R10: n_out follows bit 7 of the captured result. v_out is always 0. Neither flag carries decimal meaning.
- R11: Starts in consecutive cycles each produce their own result, one cycle later and in order, with valid held high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands and begin an operation |
| op | input | 2 | Operation code (see R1) |
| src | input | 8 | Source BCD byte |
| dst | input | 8 | Destination BCD byte |
| x_in | input | 1 | Incoming extend (carry/borrow) |
| z_in | input | 1 | Incoming zero flag |
| valid | output | 1 | Result strobe, one cycle after start |
| result | output | 8 | Registered BCD result |
| x_out | output | 1 | Extend flag out |
| c_out | output | 1 | Carry/borrow flag out |
| z_out | output | 1 | Cumulative zero flag out |
| n_out | output | 1 | Result bit 7, no decimal meaning |
| v_out | output | 1 | Overflow, always 0 |

## Verification
Two things can fall in the same cycle. One is a new start. The other is the presentation of the previous result while `valid` is high, which is the CHAIN transition. The bench provokes this with starts in consecutive cycles whose operations, extend bits and zero flags differ. It judges, on every clock, that each captured result appears exactly one cycle after its own start and that `valid` never drops between the two. A behavioural decimal model with integer arithmetic supplies the expected byte and flags for each cycle. That includes held values on idle cycles and the sticky zero flag carried across a chained byte sequence.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        BOP_ADD     = 2'b00,
        BOP_SUB     = 2'b01,
        BOP_NEG     = 2'b10,
        BOP_ADD_ALT = 2'b11
    } bcd_op_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_alu_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    input  logic               subtract,
    output logic [DIGIT_W-1:0] digit,
    output logic               cout
);

    logic [DIGIT_W:0] raw;

    always_comb begin
        if (!subtract) begin
            raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
            if (raw > 5'd9) begin
                digit = raw[DIGIT_W-1:0] + 4'd6;
                cout  = 1'b1;
            end else begin
                digit = raw[DIGIT_W-1:0];
                cout  = 1'b0;
            end
        end else begin
            raw  = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, cin};
            cout = raw[DIGIT_W];
            if (raw[DIGIT_W]) begin
                digit = raw[DIGIT_W-1:0] - 4'd6;
            end else begin
                digit = raw[DIGIT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bcd_operand_mux.sv
module bcd_operand_mux
    import bcd_alu_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic [W-1:0] left,
    output logic [W-1:0] right,
    output logic         subtract
);

    bcd_op_e op_e;
    assign op_e = bcd_op_e'(op);

    always_comb begin
        unique case (op_e)
            BOP_SUB: begin
                left     = dst;
                right    = src;
                subtract = 1'b1;
            end
            BOP_NEG: begin
                left     = '0;
                right    = dst;
                subtract = 1'b1;
            end
            BOP_ADD, BOP_ADD_ALT: begin
                left     = dst;
                right    = src;
                subtract = 1'b0;
            end
            default: begin
                left     = dst;
                right    = src;
                subtract = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
    import bcd_alu_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic [W-1:0] left,
    input  logic [W-1:0] right,
    input  logic         carry_in,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         carry_out
);

    logic [NDIGITS:0] link;
    assign link[0]   = carry_in;
    assign carry_out = link[NDIGITS];

    for (genvar g = 0; g < NDIGITS; g++) begin : g_digit
        bcd_digit_stage u_stage (
            .a        (left [g*DIGIT_W +: DIGIT_W]),
            .b        (right[g*DIGIT_W +: DIGIT_W]),
            .cin      (link[g]),
            .subtract (subtract),
            .digit    (sum[g*DIGIT_W +: DIGIT_W]),
            .cout     (link[g+1])
        );
    end

endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
    import bcd_alu_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    input  logic         x_in,
    input  logic         z_in,
    output logic         valid,
    output logic [W-1:0] result,
    output logic         x_out,
    output logic         c_out,
    output logic         z_out,
    output logic         n_out,
    output logic         v_out
);

    ctl_state_e state_q, state_d;

    logic [W-1:0] left, right, sum;
    logic         subtract, carry;

    logic [W-1:0] res_q;
    logic         x_q, c_q, z_q;

    bcd_operand_mux #(.NDIGITS(NDIGITS)) u_mux (
        .op       (op),
        .src      (src),
        .dst      (dst),
        .left     (left),
        .right    (right),
        .subtract (subtract)
    );

    bcd_digit_chain #(.NDIGITS(NDIGITS)) u_chain (
        .left      (left),
        .right     (right),
        .carry_in  (x_in),
        .subtract  (subtract),
        .sum       (sum),
        .carry_out (carry)
    );

    // Control: LAUNCH (IDLE->PRESENT), CHAIN (PRESENT->PRESENT), SETTLE (PRESENT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = start ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = start ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            x_q   <= 1'b0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
        end else if (start) begin
            res_q <= sum;
            x_q   <= carry;
            c_q   <= carry;
            z_q   <= (sum != '0) ? 1'b0 : z_in;
        end
    end

    assign valid  = (state_q == ST_PRESENT);
    assign result = res_q;
    assign x_out  = x_q;
    assign c_out  = c_q;
    assign z_out  = z_q;
    assign n_out  = res_q[W-1];
    assign v_out  = 1'b0;

    a_r7_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    a_r7_valid_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(start));

    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(z_out) && $stable(c_out) && $stable(x_out)));

    a_r6_nonzero_clears_z: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && result != '0) |-> !z_out);

    a_r6_clear_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !z_in) |=> !z_out);

    a_r5_neg_zero_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == BOP_NEG && dst == '0 && !x_in) |=> (!c_out && result == '0));

    a_r5_neg_nonzero_borrows: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == BOP_NEG && (dst != '0 || x_in)) |=> (c_out && x_out));

endmodule

// File: tb/bcd_byte_alu_tb.sv
module bcd_byte_alu_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] src = 8'h00, dst = 8'h00;
    logic       x_in = 1'b0, z_in = 1'b0;
    logic       valid;
    logic [7:0] result;
    logic       x_out, c_out, z_out, n_out, v_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_byte_alu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src), .dst(dst),
        .x_in(x_in), .z_in(z_in), .valid(valid), .result(result), .x_out(x_out),
        .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out)
    );

    // Behavioural decimal reference model
    logic       m_valid = 1'b0;
    logic [7:0] m_res = 8'h00;
    logic       m_c = 1'b0, m_z = 1'b0;
    string      m_tag = "R9";

    function automatic int to_dec(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        logic [7:0] r;
        r[7:4] = 4'((v / 10) % 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1'b0; m_res = 8'h00; m_c = 1'b0; m_z = 1'b0; m_tag = "R9";
        end else begin
            m_valid = start;
            if (start) begin
                int v;
                case (op)
                    2'b01:   begin v = to_dec(dst) - to_dec(src) - int'(x_in); m_tag = "R3"; end
                    2'b10:   begin v = 0 - to_dec(dst) - int'(x_in);           m_tag = "R4"; end
                    default: begin v = to_dec(dst) + to_dec(src) + int'(x_in); m_tag = "R2"; end
                endcase
                m_c   = (v > 99) || (v < 0);
                v     = (v + 100) % 100;
                m_res = to_bcd(v);
                m_z   = (v != 0) ? 1'b0 : z_in;
            end else begin
                m_tag = "R8";
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            bit bad;
            bad = 1'b0;
            t = m_tag;
            if (valid !== m_valid) begin bad = 1'b1; t = "R7"; end
            else if (result !== m_res || x_out !== m_c || c_out !== m_c) bad = 1'b1;
            else if (z_out !== m_z) begin bad = 1'b1; t = "R6"; end
            else if (n_out !== m_res[7] || v_out !== 1'b0) begin bad = 1'b1; t = "R10"; end
            n_tests++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: got v=%b res=%h x=%b c=%b z=%b n=%b ov=%b expected v=%b res=%h x=c=%b z=%b n=%b ov=0",
                         t, valid, result, x_out, c_out, z_out, n_out, v_out,
                         m_valid, m_res, m_c, m_z, m_res[7]);
            end
        end
    end

    task automatic do_op(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                         input logic xi, input logic zi, input logic [7:0] er,
                         input logic ec, input logic ez, input string tag);
        @(negedge clk);
        op = o; src = s; dst = d; x_in = xi; z_in = zi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_tests++;
        if (valid !== 1'b1 || result !== er || c_out !== ec || x_out !== ec || z_out !== ez) begin
            n_fail++;
            $display("FAIL %s: got v=%b res=%h x=%b c=%b z=%b expected v=1 res=%h x=c=%b z=%b",
                     tag, valid, result, x_out, c_out, z_out, er, ec, ez);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got no end of run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        n_tests++;
        if (valid !== 1'b0 || result !== 8'h00 || x_out !== 1'b0 || c_out !== 1'b0 || z_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: got v=%b res=%h x=%b c=%b z=%b expected all zero",
                     valid, result, x_out, c_out, z_out);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_op(2'b00, 8'h45, 8'h15, 1'b0, 1'b1, 8'h60, 1'b0, 1'b0, "R2");  // 15+45
        do_op(2'b00, 8'h99, 8'h99, 1'b1, 1'b0, 8'h99, 1'b1, 1'b0, "R2");  // 99+99+1
        do_op(2'b01, 8'h25, 8'h50, 1'b1, 1'b0, 8'h24, 1'b0, 1'b0, "R3");  // 50-25-1
        do_op(2'b01, 8'h99, 8'h50, 1'b0, 1'b0, 8'h51, 1'b1, 1'b0, "R3");  // 50-99 wraps
        do_op(2'b10, 8'h77, 8'h45, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, "R4");  // ten's complement
        do_op(2'b10, 8'h00, 8'h45, 1'b1, 1'b0, 8'h54, 1'b1, 1'b0, "R4");  // nine's complement
        do_op(2'b10, 8'h12, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, "R5");  // 00 negated, X=0
        do_op(2'b10, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0, "R5");  // 00 with X=1
        do_op(2'b11, 8'h38, 8'h27, 1'b1, 1'b0, 8'h66, 1'b0, 1'b0, "R1");  // code 11 adds
        do_op(2'b00, 8'h50, 8'h50, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R6");  // zero byte keeps Z
        do_op(2'b00, 8'h50, 8'h50, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R6");  // zero byte, Z clear

        // R8: idle cycles hold outputs (model compares each cycle)
        repeat (4) @(negedge clk);

        // R11: back-to-back starts, three in a row, chained 3-byte sum 999999+000001
        @(negedge clk);
        op = 2'b00; src = 8'h01; dst = 8'h99; x_in = 1'b0; z_in = 1'b1; start = 1'b1;
        @(negedge clk);
        src = 8'h00; dst = 8'h99; x_in = c_out; z_in = z_out;
        @(negedge clk);
        src = 8'h00; dst = 8'h99; x_in = c_out; z_in = z_out;
        @(negedge clk);
        start = 1'b0;
        n_tests++;
        if (result !== 8'h00 || c_out !== 1'b1 || z_out !== 1'b1) begin
            n_fail++;
            $display("FAIL R11: got res=%h c=%b z=%b expected res=00 c=1 z=1", result, c_out, z_out);
        end

        // Random valid BCD traffic, model-checked every clock
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            op    = 2'($urandom_range(0, 3));
            src   = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            dst   = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            x_in  = 1'($urandom_range(0, 1));
            z_in  = 1'($urandom_range(0, 1));
            start = ($urandom_range(0, 9) < 7);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule